// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter for a small peripheral set, accessed over an 8-bit register bus. It advances from one of two sources. The first is an internal instruction tick, which pulses once every four system clocks. The second is the rising edges of an external input. The chosen source passes through a power-of-two prescaler before it reaches the count. A run bit starts and stops counting. When the count wraps from its top value to zero, a sticky overflow flag is raised and is also driven on a dedicated output.

Software reads and writes the count one byte at a time. Two hidden byte buffers make the 16-bit accesses coherent. A read of the low byte captures the high byte at that same moment. A write of the high byte is held back until the low byte is written, and then both halves load together. The external edge path can pass through a two-flop synchronizer, or it can be used directly when the input already comes from the system clock domain.

Top module: `ptimer16`

## Requirements
- R1: After reset, reads return 0 from all four addresses (control, low count, high count, status), and `ovf_flag` is 0.
- R2: The register map is as follows. Address 0 is the control register: bit0 run, bit1 source (1 = external input), bit2 synchronizer enable, bits 5:4 prescale select. Addresses 1 and 2 are the low and high count bytes. Address 3 is status, with bit0 as the overflow flag. Read data appears on `rdata` one clock after `rd_en`.
- R3: With source 0 and run set, one internal tick occurs every 4 clocks. A write to the low count byte restarts that divider, so the first tick falls on the 4th clock edge after the write edge.
- R4: Prescale select 0, 1, 2 and 3 passes every 1st, 2nd, 4th and 8th source event respectively to the count. A write to the low count byte restarts the prescale count without changing the select.
- R5: With source 1 and the synchronizer on, each rising edge of `ext_in` adds one source event. This requires the input to stay high and low for at least 2 clocks each.
- R6: With source 1 and the synchronizer off, `ext_in` is edge-detected through a single register and also counts one event per rising edge.
- R7: While run is 0, the count holds its value.
- R8: A wrap from FFFFh to 0000h sets the overflow flag. The flag stays set until a status write with bit0 = 0 clears it. A status write with bit0 = 1 has no effect.
- R9: If a wrap and a clearing status write fall on the same clock, the flag ends up set.
- R10: A read of the low byte copies the high byte into a read buffer, and a later high-byte read returns that copy, even if the count has changed in between.
- R11: A write of the high byte changes only a buffer. The write of the low byte then loads both halves as one 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 1 | External count input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The synchronized external path assumes that `ext_in` holds each level for at least two system clocks, so that the edge detector never produces back-to-back pulses. The stimulus keeps every external high and low phase exactly two clocks long. The assertions also assume that the bus is driven with only one of read or write in a cycle. The bench drives every access from a single task per cycle. Random runs draw the preload, prescale select and run length from a fixed seed, and choose preloads near FFFFh often enough to reach the wrap.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int PS_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_STAT   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            sync_en;
    logic            src_ext;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_tick_src.sv
module tmr16_tick_src #(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic ext_in,
  input  logic src_ext,
  input  logic sync_en,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]     div_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 direct_q;
  logic                 int_tick, sync_edge, direct_edge;

  // free-running instruction tick, restarted by a counter load
  always_ff @(posedge clk) begin
    if (rst || restart) div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
  assign int_tick = (div_q == DIV_LAST);

  // synchronizer chain plus one history stage for edge detect
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
  end
  assign sync_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) direct_q <= 1'b0;
    else     direct_q <= ext_in;
  end
  assign direct_edge = ext_in & ~direct_q;

  always_comb begin
    if (!src_ext)     tick = int_tick;
    else if (sync_en) tick = sync_edge;
    else              tick = direct_edge;
  end

  AST_SYNC_EDGE_GAP: assert property (@(posedge clk) disable iff (rst)
    (src_ext && sync_en && tick) |=> !(src_ext && sync_en && tick)); // R5
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale import tmr16_pkg::*; (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            tick_in,
  input  logic [PS_W-1:0] sel,
  output logic            tick_out
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] mask;
  logic             at_end;

  assign mask     = CNT_W'((1 << sel) - 1);
  assign at_end   = ((pcnt_q & mask) == mask);
  assign tick_out = tick_in && at_end && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear)  pcnt_q <= '0;
    else if (tick_in)  pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
  end

  AST_PS_UNITY: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && tick_in && !clear) |-> tick_out); // R4
  AST_PS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pcnt_q == '0)); // R4
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs import tmr16_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          inc,
  output ctrl_t         ctrl,
  output logic          load,
  output logic [DW-1:0] rdata,
  output logic          flag
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] count_q;
  logic [DW-1:0] hi_wbuf_q, hi_rbuf_q;
  logic          clr_wr, wrap;
  reg_addr_e     sel;

  assign sel    = reg_addr_e'(addr);
  assign load   = wr_en && (sel == REG_CNT_LO);
  assign clr_wr = wr_en && (sel == REG_STAT) && !wdata[0];
  assign wrap   = inc && !load && (count_q == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_en && sel == REG_CTRL)
      ctrl <= '{ps: wdata[5:4], sync_en: wdata[2], src_ext: wdata[1], run: wdata[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) hi_wbuf_q <= '0;
    else if (wr_en && sel == REG_CNT_HI) hi_wbuf_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load) count_q <= {hi_wbuf_q, wdata};
    else if (inc)  count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (wrap)   flag <= 1'b1;
    else if (clr_wr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      hi_rbuf_q <= '0;
    end else if (rd_en) begin
      unique case (sel)
        REG_CTRL:   rdata <= {{(DW-6){1'b0}}, ctrl.ps, 1'b0, ctrl.sync_en, ctrl.src_ext, ctrl.run};
        REG_CNT_LO: begin
          rdata     <= count_q[DW-1:0];
          hi_rbuf_q <= count_q[CW-1:DW];
        end
        REG_CNT_HI: rdata <= hi_rbuf_q;
        REG_STAT:   rdata <= {{(DW-1){1'b0}}, flag};
        default:    rdata <= '0;
      endcase
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !load) |=> $stable(count_q)); // R7
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (flag && count_q == '0)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_wr) |=> flag); // R8
  AST_WRAP_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wrap && clr_wr) |=> flag); // R9
  AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == {$past(hi_wbuf_q), $past(wdata)})); // R11
endmodule

// File: rtl/ptimer16.sv
module ptimer16 import tmr16_pkg::*; #(
  parameter int DW          = 8,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ovf_flag
);
  ctrl_t ctrl;
  logic  load, raw_tick, gated_tick, inc;

  tmr16_tick_src #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .restart(load), .ext_in(ext_in),
    .src_ext(ctrl.src_ext), .sync_en(ctrl.sync_en), .tick(raw_tick));

  assign gated_tick = raw_tick & ctrl.run;

  tmr16_prescale u_ps (
    .clk(clk), .rst(rst), .clear(load), .tick_in(gated_tick),
    .sel(ctrl.ps), .tick_out(inc));

  tmr16_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .inc(inc), .ctrl(ctrl), .load(load),
    .rdata(rdata), .flag(ovf_flag));
endmodule

// File: tb/ptimer16_tb.sv
`timescale 1ns/1ps
module ptimer16_tb;
  logic       clk = 0, rst = 1, ext_in = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       ovf_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  ptimer16 u_dut (.clk(clk), .rst(rst), .ext_in(ext_in), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic read16(output int v);
    logic [7:0] lo, hi;
    rd(2'd1, lo); rd(2'd2, hi);
    v = {hi, lo};
  endtask
  function automatic logic [7:0] ctrl_word(input bit run, input bit src, input bit sy, input int ps);
    return {2'b00, 2'(ps), 1'b0, sy, src, run};
  endfunction
  // internal mode: load edge W, run set at W+1, stop at W+n+2
  function automatic int exp_int_incs(input int n, input int ps);
    return ((n + 2) / 4) >> ps;
  endfunction

  task automatic internal_run(input int init, input int ps, input int n, input string req);
    int v; logic [7:0] f; int sum;
    wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    wr(2'd2, 8'(init >> 8)); wr(2'd1, 8'(init));
    wr(2'd0, ctrl_word(1, 0, 0, ps));
    idle(n);
    wr(2'd0, ctrl_word(0, 0, 0, ps));
    sum = init + exp_int_incs(n, ps);
    read16(v); check(req, v, sum & 16'hFFFF);
    rd(2'd3, f); check("R8", f, (sum > 16'hFFFF) ? 1 : 0);
  endtask

  task automatic ext_run(input bit sy, input int ps, input int p, input string req);
    int v;
    wr(2'd0, ctrl_word(0, 1, sy, ps));
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    wr(2'd0, ctrl_word(1, 1, sy, ps));
    idle(3);
    for (int i = 0; i < p; i++) begin
      ext_in = 1; idle(2); ext_in = 0; idle(2);
    end
    idle(6);
    wr(2'd0, ctrl_word(0, 1, sy, ps));
    read16(v); check(req, v, p >> ps);
  endtask

  initial begin
    logic [7:0] d; int v, a;
    void'($urandom(32'd7341));
    idle(3); rst = 0; idle(1);
    // R1 reset state
    rd(2'd0, d); check("R1", d, 0);
    rd(2'd1, d); check("R1", d, 0);
    rd(2'd2, d); check("R1", d, 0);
    rd(2'd3, d); check("R1", d, 0);
    check("R1", ovf_flag, 0);
    // R2 control readback
    wr(2'd0, 8'h35); rd(2'd0, d); check("R2", d, 8'h35);
    wr(2'd0, 8'h00);
    // R3 / R4 internal tick and every prescale ratio
    internal_run(16'h0100, 0, 0, "R3");
    internal_run(16'h0100, 0, 37, "R3");
    for (int ps = 0; ps < 4; ps++) internal_run(16'h1200, ps, 61, "R4");
    // R7 hold while stopped
    wr(2'd2, 8'hAB); wr(2'd1, 8'hCD); idle(40);
    read16(v); check("R7", v, 16'hABCD);
    // R5 synchronized / R6 direct external
    ext_run(1, 0, 5, "R5");
    ext_run(1, 2, 9, "R5");
    ext_run(0, 0, 6, "R6");
    ext_run(0, 1, 7, "R6");
    // R8 wrap, flag, ignored write of 1, clear
    internal_run(16'hFFFF, 0, 3, "R8");
    check("R8", ovf_flag, 1);
    wr(2'd3, 8'h01); rd(2'd3, d); check("R8", d, 1);
    wr(2'd3, 8'h00); rd(2'd3, d); check("R8", d, 0);
    wr(2'd3, 8'h01); rd(2'd3, d); check("R8", d, 0);
    // R9 wrap on the same edge as a clear (tick lands at W+4)
    wr(2'd2, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd0, ctrl_word(1, 0, 0, 0));
    idle(2);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd3, d); check("R9", d, 1);
    wr(2'd3, 8'h00);
    // R10 coherent read pair
    wr(2'd2, 8'h5A); wr(2'd1, 8'h11);
    rd(2'd1, d); check("R10", d, 8'h11);
    wr(2'd2, 8'h77); wr(2'd1, 8'h22);
    rd(2'd2, d); check("R10", d, 8'h5A);
    read16(v); check("R10", v, 16'h7722);
    // R11 high write is buffered until low write
    wr(2'd2, 8'h3C);
    read16(v); check("R11", v, 16'h7722);
    wr(2'd1, 8'h99);
    read16(v); check("R11", v, 16'h3C99);
    // random internal runs
    for (int k = 0; k < 24; k++) begin
      a = (k % 3 == 0) ? (16'hFFFF - int'($urandom % 20)) : int'($urandom & 16'hFFFF);
      internal_run(a, int'($urandom % 4), int'($urandom % 80), "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule